// File: doc/BRIEF.md
# Four-Lane Shuffle and Unpack Unit

This unit rearranges the 32-bit lanes of two 128-bit operands, A and B, into a new 128-bit value. A 3-bit operation code picks one of five arrangements. The first is a shuffle steered by an 8-bit immediate. Two more interleave either the low or the high halves of A and B. The last two copy one pair of B lanes into the opposite half of A. Lanes are copied as raw bit patterns. No lane is ever read as a number, so any pattern, NaN encodings included, passes through untouched.

One lane crossbar serves every operation. A small decoder turns the operation code and immediate into a source operand and a source lane for each result lane. The result is registered. A request presented with `in_valid` high appears on the outputs one clock later, together with `out_valid`. Lane k occupies bits [32k+31:32k].

Top module: `lane_shuf_unit`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released until the first request, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R3: Op code 0 (shuffle): immediate bits [1:0] and [3:2] pick A lanes for result lanes 0 and 1. Bits [5:4] and [7:6] pick B lanes for result lanes 2 and 3.
- R4: Op code 1 (interleave low): result lanes 3..0 are B[1], A[1], B[0], A[0].
- R5: Op code 2 (interleave high): result lanes 3..0 are B[3], A[3], B[2], A[2].
- R6: Op code 3 (high pair of B to low): result lanes 0 and 1 are B[2] and B[3], and lanes 2 and 3 keep A[2] and A[3].
- R7: Op code 4 (low pair of B to high): result lanes 2 and 3 are B[0] and B[1], and lanes 0 and 1 keep A[0] and A[1].
- R8: Op codes 5, 6 and 7 return A unchanged, and the immediate has no effect on them.
- R9: In a cycle with `in_valid` low, `result` keeps its previous value whatever the other inputs carry.
- R10: Lane contents are moved bit-exact. NaN, infinity and denormal patterns arrive unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code (see R3 to R8) |
| imm | input | 8 | Shuffle lane selectors, 2 bits per result lane |
| opa | input | 128 | Operand A, lane k at bits [32k+31:32k] |
| opb | input | 128 | Operand B, lane k at bits [32k+31:32k] |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 128 | Registered rearranged value |

## Verification
Random operands with every lane distinct run under every op code and random immediates. Because each lane is unique, a result lane names the operand and the lane it came from, so a swapped A/B or a wrong index cannot hide. Directed shuffles use all-equal selector fields (0x00, 0xFF) and the identity and reversal maps (0xE4, 0x1B), which separate the field-to-lane ordering from the source choice. Special floating-point patterns check bit-exact movement. Idle cycles carry fresh junk data to show that the result holds.

// File: rtl/lane_shuf_pkg.sv
package lane_shuf_pkg;
   localparam logic [2:0] LS_OP_SHUF   = 3'd0;
   localparam logic [2:0] LS_OP_ILV_LO = 3'd1;
   localparam logic [2:0] LS_OP_ILV_HI = 3'd2;
   localparam logic [2:0] LS_OP_HI2LO  = 3'd3;
   localparam logic [2:0] LS_OP_LO2HI  = 3'd4;
endpackage

// File: rtl/lane_shuf_decode.sv
module lane_shuf_decode
   import lane_shuf_pkg::*;
#(
   parameter int LANES = 4,
   localparam int SEL_W = $clog2(LANES),
   localparam int IMM_W = LANES * SEL_W,
   localparam int HALF  = LANES / 2
) (
   input  logic [2:0]             op_sel,
   input  logic [IMM_W-1:0]       imm,
   output logic [LANES-1:0]       src_b,
   output logic [LANES*SEL_W-1:0] src_idx
);
   always_comb begin
      src_b   = '0;
      src_idx = '0;
      for (int i = 0; i < LANES; i++) begin
         logic [SEL_W-1:0] own;
         own = SEL_W'(i);
         src_b[i] = 1'b0;
         src_idx[i*SEL_W +: SEL_W] = own;
         case (op_sel)
            LS_OP_SHUF: begin
               src_b[i] = (i >= HALF);
               src_idx[i*SEL_W +: SEL_W] = imm[i*SEL_W +: SEL_W];
            end
            LS_OP_ILV_LO: begin
               src_b[i] = own[0];
               src_idx[i*SEL_W +: SEL_W] = SEL_W'(i / 2);
            end
            LS_OP_ILV_HI: begin
               src_b[i] = own[0];
               src_idx[i*SEL_W +: SEL_W] = SEL_W'(HALF + i / 2);
            end
            LS_OP_HI2LO: begin
               if (i < HALF) begin
                  src_b[i] = 1'b1;
                  src_idx[i*SEL_W +: SEL_W] = SEL_W'(i + HALF);
               end
            end
            LS_OP_LO2HI: begin
               if (i >= HALF) begin
                  src_b[i] = 1'b1;
                  src_idx[i*SEL_W +: SEL_W] = SEL_W'(i - HALF);
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/lane_shuf_xbar.sv
module lane_shuf_xbar #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   localparam int SEL_W = $clog2(LANES),
   localparam int VEC_W = LANE_W * LANES
) (
   input  logic [VEC_W-1:0]       vec_a,
   input  logic [VEC_W-1:0]       vec_b,
   input  logic [LANES-1:0]       src_b,
   input  logic [LANES*SEL_W-1:0] src_idx,
   output logic [VEC_W-1:0]       vec_out
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [SEL_W-1:0]  idx;
      logic [LANE_W-1:0] from_a;
      logic [LANE_W-1:0] from_b;
      assign idx     = src_idx[g*SEL_W +: SEL_W];
      assign from_a  = vec_a[idx*LANE_W +: LANE_W];
      assign from_b  = vec_b[idx*LANE_W +: LANE_W];
      assign vec_out[g*LANE_W +: LANE_W] = src_b[g] ? from_b : from_a;
   end
endmodule

// File: rtl/lane_shuf_unit.sv
module lane_shuf_unit #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   localparam int SEL_W = $clog2(LANES),
   localparam int IMM_W = LANES * SEL_W,
   localparam int VEC_W = LANE_W * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       op_sel,
   input  logic [IMM_W-1:0] imm,
   input  logic [VEC_W-1:0] opa,
   input  logic [VEC_W-1:0] opb,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);
   if (LANES < 2 || (1 << SEL_W) != LANES) begin : g_bad_lanes
      $error("lane_shuf_unit: LANES must be a power of two, at least 2");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("lane_shuf_unit: LANE_W must be positive");
   end

   logic [LANES-1:0]       src_b;
   logic [LANES*SEL_W-1:0] src_idx;
   logic [VEC_W-1:0]       arranged;

   lane_shuf_decode #(.LANES(LANES)) dec_i (
      .op_sel (op_sel),
      .imm    (imm),
      .src_b  (src_b),
      .src_idx(src_idx)
   );

   lane_shuf_xbar #(.LANE_W(LANE_W), .LANES(LANES)) xbar_i (
      .vec_a  (opa),
      .vec_b  (opb),
      .src_b  (src_b),
      .src_idx(src_idx),
      .vec_out(arranged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= arranged;
      end
   end

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   assert_pass_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel > 3'd4) |=> result == $past(opa));

   assert_ilv_lo_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd1) |=> result[LANE_W-1:0] == $past(opa[LANE_W-1:0]));

   assert_hi2lo_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd3) |=>
         result[VEC_W-1:VEC_W/2] == $past(opa[VEC_W-1:VEC_W/2]));
endmodule

// File: tb/lane_shuf_unit_tb_top.sv
`timescale 1ns/1ps
module lane_shuf_unit_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [2:0]   op_sel = '0;
   logic [7:0]   imm = '0;
   logic [127:0] opa = '0;
   logic [127:0] opb = '0;
   logic         out_valid;
   logic [127:0] result;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lane_shuf_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .imm(imm), .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
   );

   function automatic logic [31:0] ln(logic [127:0] v, int k);
      return v[k*32 +: 32];
   endfunction

   function automatic logic [127:0] model(logic [2:0] op, logic [7:0] im,
                                          logic [127:0] a, logic [127:0] b);
      logic [31:0] r0, r1, r2, r3;
      case (op)
         3'd0: begin
            r0 = ln(a, int'(im[1:0])); r1 = ln(a, int'(im[3:2]));
            r2 = ln(b, int'(im[5:4])); r3 = ln(b, int'(im[7:6]));
         end
         3'd1: begin r0 = ln(a,0); r1 = ln(b,0); r2 = ln(a,1); r3 = ln(b,1); end
         3'd2: begin r0 = ln(a,2); r1 = ln(b,2); r2 = ln(a,3); r3 = ln(b,3); end
         3'd3: begin r0 = ln(b,2); r1 = ln(b,3); r2 = ln(a,2); r3 = ln(a,3); end
         3'd4: begin r0 = ln(a,0); r1 = ln(a,1); r2 = ln(b,0); r3 = ln(b,1); end
         default: begin r0 = ln(a,0); r1 = ln(a,1); r2 = ln(a,2); r3 = ln(a,3); end
      endcase
      return {r3, r2, r1, r0};
   endfunction

   function automatic string req_of(logic [2:0] op);
      case (op)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check_vec(string req, logic [127:0] act, logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: result actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_bit(string req, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: out_valid actual %b expected %b", req, act, exp);
      end
   endtask

   // Drive at a falling edge, capture at the rising edge, check at the next falling edge.
   task automatic run_op(string req, logic [2:0] op, logic [7:0] im,
                         logic [127:0] a, logic [127:0] b);
      logic [127:0] exp;
      exp = model(op, im, a, b);
      in_valid = 1'b1; op_sel = op; imm = im; opa = a; opb = b;
      @(posedge clk); @(negedge clk);
      check_bit("R2", out_valid, 1'b1);
      check_vec(req, result, exp);
   endtask

   function automatic logic [127:0] rand_vec();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   logic [127:0] va = {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000};
   logic [127:0] vb = {32'hB3B3_0003, 32'hB2B2_0002, 32'hB1B1_0001, 32'hB0B0_0000};

   initial begin
      void'($urandom(32'h1234_5EED));
      repeat (3) @(negedge clk);
      check_bit("R1", out_valid, 1'b0);
      check_vec("R1", result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1", out_valid, 1'b0);
      check_vec("R1", result, '0);

      // directed shuffles
      run_op("R3", 3'd0, 8'hE4, va, vb);
      run_op("R3", 3'd0, 8'h1B, va, vb);
      run_op("R3", 3'd0, 8'h00, va, vb);
      run_op("R3", 3'd0, 8'hFF, va, vb);
      run_op("R4", 3'd1, 8'h00, va, vb);
      run_op("R5", 3'd2, 8'h00, va, vb);
      run_op("R6", 3'd3, 8'h00, va, vb);
      run_op("R7", 3'd4, 8'h00, va, vb);
      run_op("R8", 3'd5, 8'h1B, va, vb);
      run_op("R8", 3'd6, 8'hC3, va, vb);
      run_op("R8", 3'd7, 8'hFF, va, vb);
      // special floating-point patterns move bit-exact (R10)
      run_op("R10", 3'd0, 8'h4E,
             {32'h7FC0_0001, 32'hFF80_0000, 32'h0000_0001, 32'h8000_0000},
             {32'hFFFF_FFFF, 32'h7F80_0000, 32'h807F_FFFF, 32'h7FBF_FFFF});
      run_op("R10", 3'd2, 8'h00,
             {32'h7FC0_0001, 32'hFF80_0000, 32'h0000_0001, 32'h8000_0000},
             {32'hFFFF_FFFF, 32'h7F80_0000, 32'h807F_FFFF, 32'h7FBF_FFFF});

      // idle cycle: junk on inputs must not disturb the result (R9)
      begin
         logic [127:0] held;
         held = result;
         in_valid = 1'b0; op_sel = 3'd0; imm = 8'h55; opa = rand_vec(); opb = rand_vec();
         @(posedge clk); @(negedge clk);
         check_bit("R2", out_valid, 1'b0);
         check_vec("R9", result, held);
         @(posedge clk); @(negedge clk);
         check_vec("R9", result, held);
      end

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [2:0] op;
         op = 3'($urandom() % 8);
         run_op(req_of(op), op, 8'($urandom()), rand_vec(), rand_vec());
         if (($urandom() % 5) == 0) begin
            logic [127:0] held;
            held = result;
            in_valid = 1'b0; opa = rand_vec(); opb = rand_vec(); op_sel = 3'($urandom());
            @(posedge clk); @(negedge clk);
            check_bit("R2", out_valid, 1'b0);
            check_vec("R9", result, held);
         end
      end

      in_valid = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule